// File: doc/BRIEF.md
# SDRAM Bank Timing Protocol Monitor

This block watches a decoded SDRAM command stream, one command per clock with a bank number. It flags every command that breaks the row and bank timing rules of the memory. It drives nothing on the memory bus. For each bank it tracks whether a row is open, whether an auto-precharge is pending, and a down-counter for each spacing rule. A single shared counter tracks the spacing between activations to different banks.

Fixed timings (row-to-column, precharge, activate-to-activate, write recovery and write-to-read) are parameters. The burst length and the SDR/DDR beat rate are static inputs. From these two inputs the monitor derives the number of data clocks per burst (tBL), the minimum row active time and the minimum row cycle time. A command that breaks a rule is still applied to the tracked state, as the real device would see it, except that a column access to a closed bank changes nothing. In the clock after the offending command, the monitor raises a flag for one cycle together with a code that names the rule.

Top module: `sdtm_monitor`

## Requirements
- R1: cmd_op encodes 0 NOP, 1 ACTIVATE, 2 READ, 3 READ with auto-precharge, 4 WRITE, 5 WRITE with auto-precharge, 6 PRECHARGE (one bank), 7 PRECHARGE all banks, 8 REFRESH. Codes 9 to 15 act as NOP. A violation raises err_valid for one cycle, in the clock after the command, with a nonzero err_code. When there is no violation, err_valid is 0 and err_code is 0.
- R2: After reset, err_valid is low, all banks are closed and every counter is satisfied, so the first ACTIVATE to any bank is legal.
- R3: A READ or WRITE (plain or auto-precharge) to a bank with no open row gives code 1 and changes nothing. An ACTIVATE to a bank that is open or has an auto-precharge pending gives code 2.
- R4: A READ or WRITE issued fewer than T_RCD cycles after the ACTIVATE of its bank gives code 3.
- R5: tBL is the burst length divided by the beats per clock. bl_sel 0 selects a burst of 2, 1 selects 4, and 2 or 3 select 8. ddr_mode 0 gives 1 beat per clock and 1 gives 2. A PRECHARGE to an open bank fewer than T_RCD+tBL cycles after its ACTIVATE gives code 4.
- R6: An ACTIVATE fewer than T_RCD+tBL+T_RP cycles after the previous ACTIVATE to the same bank gives code 5.
- R7: An ACTIVATE fewer than T_RRD cycles after an ACTIVATE to a different bank gives code 6.
- R8: An ACTIVATE fewer than T_RP cycles after the bank was closed gives code 7. A PRECHARGE to a closed bank has no effect and starts no wait.
- R9: With a WRITE at cycle t, the last data beat falls at t+tBL-1. A PRECHARGE before t+tBL-1+T_WR gives code 8.
- R10: A READ to a bank before t+tBL-1+T_WTR, where t is the cycle of the last WRITE to that bank, gives code 9.
- R11: A READ with auto-precharge at cycle t closes the bank at t+tBL. A WRITE with auto-precharge closes it at t+tBL-1+T_WR. Between the command and the close, the bank counts as pending. After the close, the T_RP wait applies.
- R12: A REFRESH while any bank is open or pending gives code 10.
- R13: PRECHARGE all applies the precharge checks to every open bank, then closes all of them.
- R14: When several rules fail on one command, the lowest code is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 4 | Decoded command, encoded as in R1 |
| cmd_bank | input | BANK_W | Bank the command addresses |
| bl_sel | input | 2 | Burst length select (static) |
| ddr_mode | input | 1 | 1 when two beats move per clock (static) |
| err_valid | output | 1 | One-cycle violation flag |
| err_code | output | 4 | Code of the lowest violated rule, 0 when none |

## Verification
A bank counter that is loaded one cycle short or one cycle long moves the boundary of the matching rule. The error then appears, or fails to appear, on the first command placed exactly at the legal distance, in the clock that follows it. The bench therefore sweeps the spacing of each rule across its boundary, for every burst length and beat rate. A wrong open or pending flag shows up as code 1, 2 or 10 on the next column access, activation or refresh to that bank. A wrong priority shows up as a higher code on a command that breaks two rules at once.

// File: rtl/sdtm_pkg.sv
// Shared types for the SDRAM timing monitor: command encoding, rule codes
// and the burst-to-clock conversion. Codes are ordered by priority.
package sdtm_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ACT  = 4'd1,
        OP_RD   = 4'd2,
        OP_RDA  = 4'd3,
        OP_WR   = 4'd4,
        OP_WRA  = 4'd5,
        OP_PRE  = 4'd6,
        OP_PREA = 4'd7,
        OP_REF  = 4'd8
    } sd_op_e;

    typedef enum logic [3:0] {
        E_NONE     = 4'd0,
        E_RW_IDLE  = 4'd1,
        E_ACT_BUSY = 4'd2,
        E_RCD      = 4'd3,
        E_RAS      = 4'd4,
        E_RC       = 4'd5,
        E_RRD      = 4'd6,
        E_RP       = 4'd7,
        E_WR       = 4'd8,
        E_WTR      = 4'd9,
        E_REF_BUSY = 4'd10
    } sd_err_e;

    // Data clocks taken by one burst, from the length select and beat rate.
    function automatic int burst_clocks(input logic [1:0] sel, input logic two_beats);
        int beats;
        case (sel)
            2'd0:    beats = 2;
            2'd1:    beats = 4;
            default: beats = 8;
        endcase
        return two_beats ? beats / 2 : beats;
    endfunction

endpackage

// File: rtl/sdtm_bank.sv
// Per-bank tracker. Holds the open and auto-precharge-pending state and one
// down-counter per spacing rule. A counter value of zero means the rule is met.
// Reports the lowest bank-local rule that the current command breaks.
// Assumes every timing parameter is at least 1 and tbl is at least 1.
module sdtm_bank
    import sdtm_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_WR  = 3,
    parameter int T_WTR = 2,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  sd_op_e           op,
    input  logic [CNT_W-1:0] tbl,
    output sd_err_e          bank_err
);

    localparam logic [CNT_W-1:0] RCD_LD  = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RAS_OFS = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RC_OFS  = CNT_W'(T_RCD + T_RP - 1);
    localparam logic [CNT_W-1:0] RP_LD   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] WR_OFS  = CNT_W'(T_WR - 2);
    localparam logic [CNT_W-1:0] WTR_OFS = CNT_W'(T_WTR - 2);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic             open_q, ap_q;
    logic [CNT_W-1:0] rcd_q, ras_q, rc_q, rp_q, wr_q, wtr_q, apc_q;
    logic             hit_act, hit_rd, hit_wr, hit_pre, hit_ref, hit_auto;

    // Decode which events of the command concern this bank.
    always_comb begin
        hit_act  = sel && (op == OP_ACT);
        hit_rd   = sel && (op == OP_RD || op == OP_RDA);
        hit_wr   = sel && (op == OP_WR || op == OP_WRA);
        hit_auto = sel && (op == OP_RDA || op == OP_WRA);
        hit_pre  = (sel && op == OP_PRE) || (op == OP_PREA);
        hit_ref  = (op == OP_REF);
    end

    // Pick the lowest-numbered bank-local rule broken by this command.
    always_comb begin
        bank_err = E_NONE;
        if ((hit_rd || hit_wr) && !open_q)            bank_err = E_RW_IDLE;
        else if (hit_act && (open_q || ap_q))         bank_err = E_ACT_BUSY;
        else if ((hit_rd || hit_wr) && rcd_q != '0)   bank_err = E_RCD;
        else if (hit_pre && open_q && ras_q != '0)    bank_err = E_RAS;
        else if (hit_act && rc_q != '0)               bank_err = E_RC;
        else if (hit_act && rp_q != '0)               bank_err = E_RP;
        else if (hit_pre && open_q && wr_q != '0)     bank_err = E_WR;
        else if (hit_rd && wtr_q != '0)               bank_err = E_WTR;
        else if (hit_ref && (open_q || ap_q))         bank_err = E_REF_BUSY;
    end

    // Advance the counters and apply the command to the bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            ap_q   <= 1'b0;
            rcd_q  <= '0;
            ras_q  <= '0;
            rc_q   <= '0;
            rp_q   <= '0;
            wr_q   <= '0;
            wtr_q  <= '0;
            apc_q  <= '0;
        end else begin
            rcd_q <= (rcd_q == '0) ? '0 : rcd_q - ONE;
            ras_q <= (ras_q == '0) ? '0 : ras_q - ONE;
            rc_q  <= (rc_q  == '0) ? '0 : rc_q  - ONE;
            rp_q  <= (rp_q  == '0) ? '0 : rp_q  - ONE;
            wr_q  <= (wr_q  == '0) ? '0 : wr_q  - ONE;
            wtr_q <= (wtr_q == '0) ? '0 : wtr_q - ONE;
            if (ap_q) begin
                if (apc_q == '0) begin
                    ap_q <= 1'b0;
                    rp_q <= RP_LD;
                end else begin
                    apc_q <= apc_q - ONE;
                end
            end
            if (hit_pre && open_q) begin
                open_q <= 1'b0;
                rp_q   <= RP_LD;
            end
            if ((hit_rd || hit_wr) && open_q) begin
                if (hit_wr) begin
                    wr_q  <= tbl + WR_OFS;
                    wtr_q <= tbl + WTR_OFS;
                end
                if (hit_auto) begin
                    open_q <= 1'b0;
                    ap_q   <= 1'b1;
                    apc_q  <= hit_rd ? tbl - ONE : tbl + WR_OFS;
                end
            end
            if (hit_act) begin
                open_q <= 1'b1;
                ap_q   <= 1'b0;
                rcd_q  <= RCD_LD;
                ras_q  <= tbl + RAS_OFS;
                rc_q   <= tbl + RC_OFS;
            end
        end
    end

    // R11: a bank is never open and pending auto-precharge at once.
    p_open_or_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_q && ap_q));

    // R11: a pending close that expires starts the precharge wait.
    p_auto_close_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_q && apc_q == '0 && !hit_act) |=> (!ap_q && rp_q == RP_LD));

    // R5: since tRAS exceeds tRCD, a legal precharge always finds tRCD met.
    p_ras_after_rcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pre && open_q && ras_q == '0) |-> (rcd_q == '0));

endmodule

// File: rtl/sdtm_act_spacing.sv
// Shared activate-to-activate spacing tracker across banks. Remembers the
// bank of the last ACTIVATE and counts down the spacing to a different bank.
module sdtm_act_spacing
    import sdtm_pkg::*;
#(
    parameter int T_RRD  = 2,
    parameter int BANK_W = 2,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic [BANK_W-1:0] bank,
    output sd_err_e           rrd_err
);

    localparam logic [CNT_W-1:0] RRD_LD = CNT_W'(T_RRD - 1);

    logic [CNT_W-1:0]  rrd_q;
    logic [BANK_W-1:0] last_q;

    // Flag an ACTIVATE to another bank before the spacing has run out.
    always_comb begin
        rrd_err = (act && rrd_q != '0 && bank != last_q) ? E_RRD : E_NONE;
    end

    // Restart the spacing on every ACTIVATE, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q  <= '0;
            last_q <= '0;
        end else if (act) begin
            rrd_q  <= RRD_LD;
            last_q <= bank;
        end else if (rrd_q != '0) begin
            rrd_q <= rrd_q - CNT_W'(1);
        end
    end

    // R7: the spacing counter never exceeds its load value.
    p_rrd_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rrd_q <= RRD_LD);

endmodule

// File: rtl/sdtm_err_merge.sv
// Reduces the rule codes of all sources to the lowest nonzero code.
module sdtm_err_merge
    import sdtm_pkg::*;
#(
    parameter int NUM_SRC = 5
) (
    input  sd_err_e codes [NUM_SRC],
    output sd_err_e best
);

    // Walk all sources and keep the smallest nonzero code.
    always_comb begin
        best = E_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (codes[i] != E_NONE && (best == E_NONE || codes[i] < best))
                best = codes[i];
        end
    end

endmodule

// File: rtl/sdtm_monitor.sv
// Passive SDRAM bank timing monitor. Takes one decoded command per clock and
// reports, in the following clock, the lowest rule that the command breaks.
// Assumes bl_sel and ddr_mode stay static while commands flow.
module sdtm_monitor
    import sdtm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 3,
    parameter int T_WTR     = 2,
    parameter int CNT_W     = 6,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int NUM_SRC  = NUM_BANKS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [1:0]        bl_sel,
    input  logic              ddr_mode,
    output logic              err_valid,
    output logic [3:0]        err_code
);

    sd_op_e           op;
    logic [CNT_W-1:0] tbl;
    sd_err_e          codes [NUM_SRC];
    sd_err_e          worst;

    // Decode the opcode and the burst duration in clocks.
    always_comb begin
        op  = sd_op_e'(cmd_op);
        tbl = CNT_W'(burst_clocks(bl_sel, ddr_mode));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdtm_bank #(
            .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_WTR(T_WTR), .CNT_W(CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (cmd_bank == BANK_W'(b)),
            .op      (op),
            .tbl     (tbl),
            .bank_err(codes[b])
        );
    end

    sdtm_act_spacing #(
        .T_RRD(T_RRD), .BANK_W(BANK_W), .CNT_W(CNT_W)
    ) u_spacing (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (op == OP_ACT),
        .bank   (cmd_bank),
        .rrd_err(codes[NUM_BANKS])
    );

    sdtm_err_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .codes(codes),
        .best (worst)
    );

    // Register the flag and code so each violation is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_code  <= 4'd0;
        end else begin
            err_valid <= (worst != E_NONE);
            err_code  <= worst;
        end
    end

    // R1: the flag and the code agree.
    p_flag_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid == (err_code != 4'd0));

    // R1: a NOP is never reported.
    p_nop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd0) |=> !err_valid);

    // R7: a spacing report always follows an ACTIVATE.
    p_rrd_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == 4'd6) |-> ($past(cmd_op) == 4'd1));

    // R10: a write-to-read report always follows a READ.
    p_wtr_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == 4'd9) |-> ($past(cmd_op) == 4'd2 || $past(cmd_op) == 4'd3));

    // R12: a refresh report always follows a REFRESH.
    p_ref_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == 4'd10) |-> ($past(cmd_op) == 4'd8));

endmodule

// File: tb/tb_sdtm_monitor.sv
// Sweeps every spacing rule across its boundary for all burst settings.
module tb_sdtm_monitor;

    localparam int CLK_P = 10;
    localparam int RCD = 3, RP = 3, RRD = 2, WRC = 3, WTR = 2;
    localparam logic [3:0] NOP = 0, ACT = 1, RD = 2, RDA = 3, WR = 4, WRA = 5,
                           PRE = 6, PREA = 7, REF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic [1:0] bl_sel = 2'd0;
    logic       ddr_mode = 1'b0;
    logic       err_valid;
    logic [3:0] err_code;
    logic       got_v;
    logic [3:0] got_c;
    int         checks = 0;
    int         errors = 0;

    sdtm_monitor dut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .bl_sel(bl_sel), .ddr_mode(ddr_mode), .err_valid(err_valid), .err_code(err_code)
    );

    always #(CLK_P / 2) clk = ~clk;

    // One command for one clock; captures the registered response.
    task automatic step(input logic [3:0] op, input logic [1:0] b);
        cmd_op = op;
        cmd_bank = b;
        @(posedge clk);
        #1;
        got_v = err_valid;
        got_c = err_code;
        cmd_op = NOP;
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(NOP, 2'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        nops(2);
        rst_n = 1'b1;
    endtask

    task automatic chk(input string req, input int exp);
        checks++;
        if (got_c != 4'(exp) || got_v != (exp != 0)) begin
            errors++;
            $display("FAIL %s: got valid=%0d code=%0d, expected code=%0d (bl_sel=%0d ddr=%0d)",
                     req, got_v, got_c, exp, bl_sel, ddr_mode);
        end
    endtask

    function automatic int tbl_of(input logic [1:0] s, input logic d);
        int bl;
        bl = (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
        return d ? bl / 2 : bl;
    endfunction

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2: reset state and first activate.
        do_reset();
        got_v = err_valid; got_c = err_code;
        chk("R2 reset flag", 0);
        step(RD, 2'd3);  chk("R2 closed after reset", 1);
        step(ACT, 2'd3); chk("R2 first activate", 0);

        // R1: codes 9..15 do nothing; bank stays closed.
        do_reset();
        for (int c = 9; c < 16; c++) begin
            step(4'(c), 2'd0); chk("R1 unused code", 0);
        end
        step(WR, 2'd0); chk("R1 unused left bank closed", 1);

        // R3: activate to an open bank.
        do_reset();
        step(ACT, 2'd2); nops(20);
        step(ACT, 2'd2); chk("R3 act open bank", 2);

        // R4: row-to-column spacing.
        for (int g = 1; g <= 5; g++) begin
            do_reset();
            step(ACT, 2'd0); nops(g - 1);
            step(RD, 2'd0); chk("R4 rcd", (g < RCD) ? 3 : 0);
        end

        // R5, R9, R10, R11: swept over every burst setting.
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 3; s++) begin
                int tb, tras;
                bl_sel = 2'(s); ddr_mode = d[0];
                tb = tbl_of(bl_sel, ddr_mode);
                tras = RCD + tb;
                for (int g = 1; g <= tras + 1; g++) begin
                    do_reset();
                    step(ACT, 2'd1); nops(g - 1);
                    step(PRE, 2'd1); chk("R5 ras", (g < tras) ? 4 : 0);
                end
                for (int g = 1; g <= tb + 3; g++) begin
                    do_reset();
                    step(ACT, 2'd2); nops(2);
                    step(WR, 2'd2); nops(g - 1);
                    step(PRE, 2'd2);
                    chk("R9 write recovery", (g < tb) ? 4 : (g < tb - 1 + WRC) ? 8 : 0);
                end
                for (int g = 1; g <= tb + 2; g++) begin
                    do_reset();
                    step(ACT, 2'd0); nops(2);
                    step(WR, 2'd0); nops(g - 1);
                    step(RD, 2'd0); chk("R10 wtr", (g < tb - 1 + WTR) ? 9 : 0);
                end
                for (int g = 1; g <= tb + 4; g++) begin
                    do_reset();
                    step(ACT, 2'd0); nops(2);
                    step(RDA, 2'd0); nops(g - 1);
                    step(ACT, 2'd0);
                    chk("R11 read autoprecharge", (g <= tb) ? 2 : (g < tb + RP) ? 5 : 0);
                end
                for (int g = 1; g <= tb + 6; g++) begin
                    do_reset();
                    step(ACT, 2'd0); nops(2);
                    step(WRA, 2'd0); nops(g - 1);
                    step(ACT, 2'd0);
                    chk("R11 write autoprecharge",
                        (g <= tb - 1 + WRC) ? 2 : (g < tb - 1 + WRC + RP) ? 7 : 0);
                end
            end
        end
        bl_sel = 2'd0; ddr_mode = 1'b0;

        // R11: column access after auto-precharge sees a closed bank.
        do_reset();
        step(ACT, 2'd0); nops(2);
        step(RDA, 2'd0);
        step(RD, 2'd0); chk("R11 access while pending", 1);

        // R6: row cycle time after a premature precharge (tRC = 8 here).
        for (int g = 1; g <= 9; g++) begin
            do_reset();
            step(ACT, 2'd0);
            step(PRE, 2'd0); nops(g - 1);
            step(ACT, 2'd0); chk("R6 rc", (1 + g < RCD + 2 + RP) ? 5 : 0);
        end

        // R8: precharge wait alone, and precharge to a closed bank.
        for (int g = 1; g <= 4; g++) begin
            do_reset();
            step(ACT, 2'd0); nops(19);
            step(PRE, 2'd0); nops(g - 1);
            step(ACT, 2'd0); chk("R8 rp", (g < RP) ? 7 : 0);
        end
        do_reset();
        step(PRE, 2'd0); chk("R8 idle precharge", 0);
        step(ACT, 2'd0); chk("R8 idle precharge no wait", 0);

        // R7: spacing between activations to different banks.
        for (int g = 1; g <= 3; g++) begin
            do_reset();
            step(ACT, 2'd0); nops(g - 1);
            step(ACT, 2'd1); chk("R7 rrd", (g < RRD) ? 6 : 0);
        end

        // R13: precharge-all with one young bank, then all closed.
        do_reset();
        step(ACT, 2'd0); nops(1);
        step(ACT, 2'd1); nops(2);
        step(PREA, 2'd0); chk("R13 precharge all", 4);
        nops(2);
        step(ACT, 2'd0); chk("R13 bank closed by precharge all", 0);

        // R12: refresh legality.
        do_reset();
        step(REF, 2'd0); chk("R12 refresh idle", 0);
        step(ACT, 2'd2); nops(1);
        step(REF, 2'd0); chk("R12 refresh open", 10);
        do_reset();
        step(ACT, 2'd0); nops(2);
        step(RDA, 2'd0);
        step(REF, 2'd0); chk("R12 refresh pending", 10);
        nops(1);
        step(REF, 2'd0); chk("R12 refresh after close", 0);

        // R14: lowest code wins.
        do_reset();
        step(ACT, 2'd0);
        step(ACT, 2'd0); chk("R14 busy over rc", 2);
        do_reset();
        step(ACT, 2'd0); nops(1);
        step(ACT, 2'd1);
        step(ACT, 2'd0); chk("R14 busy over rrd", 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule